// File: doc/BRIEF.md
# Attribute-Typed Configuration Register Bank

A bank of 32-bit control and status registers. Each bit is assigned one access class, and that class decides how software traffic affects the bit. The classes are:

- boot-loaded
- hardware-driven read-only
- clear-on-read with writes ignored
- clear-on-read with writes accepted
- plain read/write
- reserved

Software uses a synchronous port with an address, a read strobe, a write strobe, write data and read data. Read data is combinational during the strobe cycle and shows the value held before any clear. A clear caused by a read takes effect at the following clock edge.

A separate loader port stands in for strap pins or a serial-memory boot loader. It may write the boot-loaded bits only while the load window is open, which is while `load_done` is low. While the window is open, software sees zero and causes no side effects. Hardware may set clear-on-read bits through `hw_set`, and it drives the read-only bits through `hw_level`.

Default map, with address, bit range and class:

| Address | Bits | Class |
|---|---|---|
| 0 | 7:0 | boot-loaded |
| 0 | 15:8 | read/write |
| 0 | 23:16 | read-only |
| 0 | 31:24 | reserved |
| 1 | 15:0 | clear-on-read, writes ignored |
| 1 | 31:16 | clear-on-read, writes accepted |
| 2 | 15:0 | read/write |
| 2 | 31:16 | read-only |
| 3 | all bits | reserved |
| 4 to 7 | none | unmapped |

Register *k* uses bits `[32k+31:32k]` of `hw_set` and `hw_level`.

Top module: `cfgbank`

## Requirements
- R1: After reset, every stored bit (boot-loaded, read/write and both clear-on-read classes) is 0.
- R2: A loader write while `load_done` is 0 copies `ld_wdata` into the boot-loaded bits of register `ld_addr`. Software writes never change those bits. Loader writes made once `load_done` is 1 are ignored.
- R3: A read-only bit reads as the value `hw_level` had at the clock edge before the read cycle. Software writes to it are ignored.
- R4: A clear-on-read bit with writes ignored is set by a 1 on its `hw_set` bit. A read returns the bit and clears it at the next edge. A software write does not change it.
- R5: A clear-on-read bit with writes accepted takes the software write data. A read returns the bit and clears it at the next edge.
- R6: A read/write bit stores the software write data. Reads of it do not change it.
- R7: Reserved bits read as 0, and writes to them are ignored.
- R8: When a `hw_set` bit is 1 in the same cycle that a read clears that clear-on-read bit, the bit holds 1 after the edge.
- R9: While `load_done` is 0, `sw_rdata` is 0 and software reads and writes change no bit.
- R10: A read of an unmapped address (4 to 7) returns 0, and a write to one changes no register.
- R11: `sw_rdata` is 0 in any cycle where `sw_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Loader write strobe |
| ld_addr | input | 3 | Loader register address |
| ld_wdata | input | 32 | Loader write data |
| load_done | input | 1 | High once the load window has closed |
| sw_rd | input | 1 | Software read strobe |
| sw_wr | input | 1 | Software write strobe |
| sw_addr | input | 3 | Software register address |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data, valid in the strobe cycle |
| hw_set | input | 128 | Per-bit set pulses for clear-on-read bits |
| hw_level | input | 128 | Hardware values for read-only bits |

## Verification
The bench goes after the following corner cases:

- **Read-then-read.** A design that cleared during the strobe cycle would return zero on the first read. A design that never cleared would repeat the old value on the second read.
- **Set pulse meeting a clearing read.** Letting the clear win would silently drop an event, and the read after it would show 0.
- **Writes across mixed-class registers.** Writes of all ones expose any leak into read-only, boot-loaded, reserved or write-ignoring clear-on-read bits.
- **Accesses before the load window closes and to unmapped addresses.** These must leave every register untouched. A pre-window read that consumed a pending event would show up as a missing bit later.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
   localparam int unsigned DEF_NREGS = 4;
   localparam int unsigned DEF_DW    = 32;

   localparam logic [DEF_NREGS-1:0][DEF_DW-1:0] DEF_BOOT_M =
      {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_00FF};
   localparam logic [DEF_NREGS-1:0][DEF_DW-1:0] DEF_RW_M =
      {32'h0000_0000, 32'h0000_FFFF, 32'h0000_0000, 32'h0000_FF00};
   localparam logic [DEF_NREGS-1:0][DEF_DW-1:0] DEF_RO_M =
      {32'h0000_0000, 32'hFFFF_0000, 32'h0000_0000, 32'h00FF_0000};
   localparam logic [DEF_NREGS-1:0][DEF_DW-1:0] DEF_COR_M =
      {32'h0000_0000, 32'h0000_0000, 32'h0000_FFFF, 32'h0000_0000};
   localparam logic [DEF_NREGS-1:0][DEF_DW-1:0] DEF_CORW_M =
      {32'h0000_0000, 32'h0000_0000, 32'hFFFF_0000, 32'h0000_0000};

   // nonzero when any two class masks claim the same bit
   function automatic logic [DEF_DW-1:0] class_overlap(
      input logic [DEF_DW-1:0] a, input logic [DEF_DW-1:0] b,
      input logic [DEF_DW-1:0] c, input logic [DEF_DW-1:0] d,
      input logic [DEF_DW-1:0] e);
      return (a & (b | c | d | e)) | (b & (c | d | e)) | (c & (d | e)) | (d & e);
   endfunction
endpackage

// File: rtl/cfgbank_decode.sv
module cfgbank_decode #(
   parameter int unsigned NREGS = 4,
   parameter int unsigned AW    = 3
) (
   input  logic             sw_rd,
   input  logic             sw_wr,
   input  logic [AW-1:0]    sw_addr,
   input  logic             ld_we,
   input  logic [AW-1:0]    ld_addr,
   input  logic             load_done,
   output logic [NREGS-1:0] rd_sel,
   output logic [NREGS-1:0] wr_sel,
   output logic [NREGS-1:0] ld_sel
);
   genvar gi;
   generate
      for (gi = 0; gi < NREGS; gi++) begin : g_sel
         assign rd_sel[gi] = sw_rd & load_done & (sw_addr == AW'(gi));
         assign wr_sel[gi] = sw_wr & load_done & (sw_addr == AW'(gi));
         assign ld_sel[gi] = ld_we & ~load_done & (ld_addr == AW'(gi));
      end
   endgenerate
endmodule

// File: rtl/cfgbank_reg.sv
module cfgbank_reg #(
   parameter int unsigned DW      = 32,
   parameter logic [DW-1:0] BOOT_M = '0,
   parameter logic [DW-1:0] RO_M   = '0,
   parameter logic [DW-1:0] COR_M  = '0,
   parameter logic [DW-1:0] CORW_M = '0,
   parameter logic [DW-1:0] RW_M   = '0,
   parameter bit RO_FLOP           = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_en,
   input  logic [DW-1:0] ld_data,
   input  logic          rd_en,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] set_in,
   input  logic [DW-1:0] level_in,
   output logic [DW-1:0] value
);
   localparam logic [DW-1:0] CLR_M   = COR_M | CORW_M;
   localparam logic [DW-1:0] WR_M    = RW_M | CORW_M;
   localparam logic [DW-1:0] STORE_M = BOOT_M | CLR_M | RW_M;

   logic [DW-1:0] q_r, q_n, ro_v;

   always_comb begin
      q_n = q_r;
      if (ld_en) q_n = (q_n & ~BOOT_M) | (ld_data & BOOT_M);
      if (rd_en) q_n = q_n & ~CLR_M;
      if (wr_en) q_n = (q_n & ~WR_M) | (wdata & WR_M);
      q_n = (q_n | (set_in & CLR_M)) & STORE_M;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= q_n;
   end

   generate
      if (RO_FLOP) begin : g_ro_flop
         logic [DW-1:0] ro_r;
         always_ff @(posedge clk) begin
            if (!rst_n) ro_r <= '0;
            else        ro_r <= level_in & RO_M;
         end
         assign ro_v = ro_r;
      end else begin : g_ro_comb
         assign ro_v = level_in & RO_M;
      end
   endgenerate

   assign value = (q_r & STORE_M) | ro_v;

   // R2: boot-loaded bits move only on a loader write
   a_r2_boot_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> $stable(q_r & BOOT_M));
   // R4: after a read, write-ignoring clear-on-read bits hold only fresh sets
   a_r4_cor_clear: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> ((q_r & COR_M) == ($past(set_in) & COR_M)));
   // R5: same for write-accepting clear-on-read bits when no write coincides
   a_r5_corw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en) |=> ((q_r & CORW_M) == ($past(set_in) & CORW_M)));
   // R6: read/write bits hold without a write
   a_r6_rw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q_r & RW_M));
   // R8: a set always lands
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_in & CLR_M) != '0) |=>
      ((q_r & $past(set_in) & CLR_M) == ($past(set_in) & CLR_M)));
endmodule

// File: rtl/cfgbank.sv
module cfgbank
   import cfgbank_pkg::*;
#(
   parameter int unsigned NREGS = DEF_NREGS,
   parameter int unsigned DW    = DEF_DW,
   parameter int unsigned AW    = 3,
   parameter bit RO_FLOP        = 1'b1,
   parameter logic [NREGS-1:0][DW-1:0] BOOT_MASK = DEF_BOOT_M,
   parameter logic [NREGS-1:0][DW-1:0] RO_MASK   = DEF_RO_M,
   parameter logic [NREGS-1:0][DW-1:0] COR_MASK  = DEF_COR_M,
   parameter logic [NREGS-1:0][DW-1:0] CORW_MASK = DEF_CORW_M,
   parameter logic [NREGS-1:0][DW-1:0] RW_MASK   = DEF_RW_M
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld_we,
   input  logic [AW-1:0]       ld_addr,
   input  logic [DW-1:0]       ld_wdata,
   input  logic                load_done,
   input  logic                sw_rd,
   input  logic                sw_wr,
   input  logic [AW-1:0]       sw_addr,
   input  logic [DW-1:0]       sw_wdata,
   output logic [DW-1:0]       sw_rdata,
   input  logic [NREGS*DW-1:0] hw_set,
   input  logic [NREGS*DW-1:0] hw_level
);
   localparam int unsigned SPAN = 1 << AW;

   generate
      if (NREGS < 1 || DW < 1) begin : g_bad_size
         $error("cfgbank: NREGS and DW must be positive");
      end
      if (SPAN < NREGS) begin : g_bad_aw
         $error("cfgbank: AW too narrow for NREGS");
      end
   endgenerate

   logic [NREGS-1:0] rd_sel, wr_sel, ld_sel;
   logic [NREGS-1:0][DW-1:0] reg_val;

   cfgbank_decode #(.NREGS(NREGS), .AW(AW)) u_dec (
      .sw_rd(sw_rd), .sw_wr(sw_wr), .sw_addr(sw_addr),
      .ld_we(ld_we), .ld_addr(ld_addr), .load_done(load_done),
      .rd_sel(rd_sel), .wr_sel(wr_sel), .ld_sel(ld_sel));

   genvar gi;
   generate
      for (gi = 0; gi < NREGS; gi++) begin : g_reg
         if (DW'(class_overlap(DEF_DW'(BOOT_MASK[gi]), DEF_DW'(RO_MASK[gi]),
               DEF_DW'(COR_MASK[gi]), DEF_DW'(CORW_MASK[gi]),
               DEF_DW'(RW_MASK[gi]))) != '0) begin : g_overlap
            $error("cfgbank: a bit is in more than one access class");
         end
         cfgbank_reg #(
            .DW(DW), .BOOT_M(BOOT_MASK[gi]), .RO_M(RO_MASK[gi]),
            .COR_M(COR_MASK[gi]), .CORW_M(CORW_MASK[gi]),
            .RW_M(RW_MASK[gi]), .RO_FLOP(RO_FLOP)
         ) u_reg (
            .clk(clk), .rst_n(rst_n),
            .ld_en(ld_sel[gi]), .ld_data(ld_wdata),
            .rd_en(rd_sel[gi]), .wr_en(wr_sel[gi]), .wdata(sw_wdata),
            .set_in(hw_set[gi*DW +: DW]), .level_in(hw_level[gi*DW +: DW]),
            .value(reg_val[gi]));
      end
   endgenerate

   always_comb begin
      sw_rdata = '0;
      for (int i = 0; i < NREGS; i++)
         if (rd_sel[i]) sw_rdata = sw_rdata | reg_val[i];
   end

   // R9: nothing visible before the load window closes
   a_r9_closed_window: assert property (@(posedge clk) disable iff (!rst_n)
      !load_done |-> (sw_rdata == '0));
   // R11: idle read port returns zero
   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_rd |-> (sw_rdata == '0));
   // at most one register answers a read
   a_r10_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_sel));
endmodule

// File: tb/cfgbank_test.sv
module cfgbank_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_we = 1'b0;
   logic [2:0] ld_addr = '0;
   logic [31:0] ld_wdata = '0;
   logic load_done = 1'b0;
   logic sw_rd = 1'b0, sw_wr = 1'b0;
   logic [2:0] sw_addr = '0;
   logic [31:0] sw_wdata = '0;
   logic [31:0] sw_rdata;
   logic [127:0] hw_set = '0;
   logic [127:0] hw_level = '0;

   always #4 clk = ~clk;

   cfgbank uut (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
      .ld_wdata(ld_wdata), .load_done(load_done), .sw_rd(sw_rd),
      .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
      .sw_rdata(sw_rdata), .hw_set(hw_set), .hw_level(hw_level));

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // monitor: compare read data in the middle of each strobe cycle
   always @(negedge clk) begin
      if (rst_n && sw_rd) begin
         if (sb.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL scoreboard: unexpected read, actual %h expected none", sw_rdata);
         end else begin
            item_t it;
            it = sb.pop_front();
            n_chk++;
            if (sw_rdata !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", it.tag, sw_rdata, it.exp);
            end
         end
      end
   end

   task automatic idle();
      sw_rd = 0; sw_wr = 0; ld_we = 0; hw_set = '0;
   endtask

   // one-cycle stimulus, then one idle cycle
   task automatic acc(input bit rd, input bit wr, input logic [2:0] a,
                      input logic [31:0] wd, input logic [127:0] setv,
                      input logic [31:0] exp, input string tag);
      item_t it;
      @(posedge clk); #1;
      sw_rd = rd; sw_wr = wr; sw_addr = a; sw_wdata = wd; hw_set = setv;
      if (rd) begin
         it.exp = exp; it.tag = tag;
         sb.push_back(it);
      end
      @(posedge clk); #1;
      idle();
   endtask

   task automatic ldw(input logic [2:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      ld_we = 1; ld_addr = a; ld_wdata = d;
      @(posedge clk); #1;
      idle();
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      acc(1, 0, a, '0, '0, exp, tag);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      acc(0, 1, a, d, '0, '0, "");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      hw_level = {32'h0, 32'hBEEF_0000, 32'h0, 32'h003C_0000};
      repeat (4) @(posedge clk);
      @(negedge clk);
      n_chk++;
      if (sw_rdata !== 32'h0) begin
         n_bad++;
         $display("FAIL R11: actual %h expected 00000000", sw_rdata);
      end
      @(posedge clk); #1; rst_n = 1;

      // window open: hardware event, then software accesses that must not act
      acc(0, 0, 3'd1, '0, 128'h1 << 32, '0, "");
      rd(3'd1, 32'h0, "R9 read before load_done");
      wr(3'd2, 32'h0000_1234);
      ldw(3'd0, 32'hA5A5_A5A5);
      @(posedge clk); #1; load_done = 1;

      rd(3'd0, 32'h003C_00A5, "R1/R2/R3/R7 reg0 after load");
      rd(3'd1, 32'h0000_0001, "R9/R4 event kept through early read");
      rd(3'd1, 32'h0, "R4 second read cleared");
      rd(3'd2, 32'hBEEF_0000, "R9/R1 early write ignored");

      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, 32'h003C_FFA5, "R2/R3/R6/R7 mixed write reg0");
      ldw(3'd0, 32'h0000_0011);
      rd(3'd0, 32'h003C_FFA5, "R2 late loader write ignored");

      wr(3'd1, 32'hABCD_1234);
      rd(3'd1, 32'hABCD_0000, "R5/R4 write lands only on write-accepting bits");
      rd(3'd1, 32'h0, "R5 cleared after read");

      wr(3'd2, 32'h5555_AAAA);
      rd(3'd2, 32'hBEEF_AAAA, "R6/R3 reg2 first read");
      rd(3'd2, 32'hBEEF_AAAA, "R6 read does not disturb");

      wr(3'd3, 32'hFFFF_FFFF);
      rd(3'd3, 32'h0, "R7 fully reserved register");

      wr(3'd5, 32'hFFFF_FFFF);
      rd(3'd5, 32'h0, "R10 unmapped read");
      rd(3'd2, 32'hBEEF_AAAA, "R10 unmapped write left reg2");
      rd(3'd1, 32'h0, "R10 unmapped write left reg1");

      acc(1, 0, 3'd1, '0, 128'h8 << 32, 32'h0, "R8 read with set, old value");
      rd(3'd1, 32'h0000_0008, "R8 set survived clear");
      rd(3'd1, 32'h0, "R8 then cleared");
      acc(1, 0, 3'd1, '0, 128'h1 << 52, 32'h0, "R8 write-accepting class old value");
      rd(3'd1, 32'h0010_0000, "R8 write-accepting set survived");
      acc(0, 0, 3'd1, '0, 128'h4 << 32, '0, "");
      acc(1, 0, 3'd1, '0, 128'h4 << 32, 32'h0000_0004, "R8 held bit re-set on read");
      rd(3'd1, 32'h0000_0004, "R8 bit still set");
      rd(3'd1, 32'h0, "R4 finally cleared");

      hw_level = {32'h0, 32'hBEEF_0000, 32'h0, 32'h0077_0000};
      @(posedge clk);
      rd(3'd0, 32'h0077_FFA5, "R3 hardware level change seen");

      repeat (3) @(posedge clk);
      if (sb.size() != 0) begin
         n_chk++; n_bad++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule